// File: doc/BRIEF.md
# PFC Startup and Protection Sequencer

This block brings a power-factor-correction stage from cold to regulated operation. It works from two digitised samples: the DC bus voltage and the input current. At power-up the inrush-bypass relay stays open and switching is off, so the bus charges through the inrush limiter. Once the bus passes the relay threshold, the relay closes and a timed settling wait starts. When the wait ends, switching is enabled and a bus-voltage reference is handed to the external voltage loop. The reference starts at the bus voltage measured at that moment and climbs in fixed steps to the rated level.

After the ramp the block is in its running state. There, a light-load burst mode can be requested by an input. In burst mode, switching is gated by a hysteresis band on the bus voltage. An overcurrent sample in any state latches a trip state. The trip state forces switching off and raises a fault flag, and only a module reset clears it. The loop arithmetic and the pulse generation sit outside this block.

Top module: `pfc_start_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `relay_on_o`, `pwm_en_o` and `fault_o` are 0 and `vref_o` is 0.
- R2: The bus sample `vbus_i` is unsigned at 1 V per LSB. With the relay open, a sample of 100 or less keeps the relay open. A sample above 100 closes the relay on the next clock edge. Once closed, the relay never opens again before reset.
- R3: `pwm_en_o` rises exactly WAIT_CYC clock edges after the edge that closed the relay, where WAIT_CYC = CLK_HZ / 1000 * WAIT_MS.
- R4: On the edge that enables switching, `vref_o` is loaded with `vbus_i`, clamped to the rated level of 385.
- R5: During the ramp, `vref_o` grows by RAMP_STEP once every RAMP_TICK cycles. It saturates at 385, and it never decreases after being loaded.
- R6: The current sample `iin_i` is unsigned at 0.1 A per LSB. A value above 210 in any state sets `fault_o` and clears `pwm_en_o` on the next edge. Both then hold until reset, whatever the inputs do. A value of exactly 210 does not trip. Tripping leaves `relay_on_o` and `vref_o` at their values.
- R7: In the running state with `burst_en_i` high, switching stops when `vbus_i` is 385 or more and restarts when `vbus_i` is 375 or less. Between these levels the previous switching state is kept.
- R8: With `burst_en_i` low in the running state, or at any time during the ramp, the bus voltage has no effect on `pwm_en_o`, which stays 1.
- R9: `pwm_en_o` is never 1 while `relay_on_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset; also the only way out of a trip |
| vbus_i | input | VBUS_W | Bus voltage sample, 1 V per LSB |
| iin_i | input | IIN_W | Input current sample, 0.1 A per LSB |
| burst_en_i | input | 1 | Requests light-load burst gating in the running state |
| relay_on_o | output | 1 | Inrush-bypass relay drive |
| pwm_en_o | output | 1 | Switching enable to the pulse generator |
| vref_o | output | VBUS_W | Bus-voltage reference for the voltage loop, 1 V per LSB |
| fault_o | output | 1 | Latched overcurrent trip flag |

## Verification
A wrong sequencer state shows up within one clock edge as a mismatched combination on the ports. Examples are switching enabled with the relay open, or the fault flag set while switching is still enabled. The bench therefore samples every output on the cycle after each stimulus. A timer that is off by one moves the rising edge of `pwm_en_o` one cycle away from the exact count, so that edge is checked on both neighbouring cycles. A corrupted ramp or burst state appears as a wrong reference value after one tick, or as a switching level that disagrees with the hysteresis history.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;
    typedef enum logic [2:0] {
        ST_PRECH = 3'd0,
        ST_WAIT  = 3'd1,
        ST_RAMP  = 3'd2,
        ST_RUN   = 3'd3,
        ST_TRIP  = 3'd4
    } seq_st_e;
endpackage

// File: rtl/pfc_seq_thresh.sv
module pfc_seq_thresh #(
    parameter int VBUS_W     = 10,
    parameter int IIN_W      = 9,
    parameter int RELAY_V    = 100,
    parameter int RATED_V    = 385,
    parameter int BURST_LO_V = 375,
    parameter int OC_LIMIT   = 210
) (
    input  logic [VBUS_W-1:0] vbus,
    input  logic [IIN_W-1:0]  iin,
    output logic              above_relay,
    output logic              at_rated,
    output logic              below_lo,
    output logic              over_cur
);
    always_comb begin
        above_relay = vbus >  VBUS_W'(RELAY_V);
        at_rated    = vbus >= VBUS_W'(RATED_V);
        below_lo    = vbus <= VBUS_W'(BURST_LO_V);
        over_cur    = iin  >  IIN_W'(OC_LIMIT);
    end
endmodule

// File: rtl/pfc_seq_ramp_step.sv
module pfc_seq_ramp_step #(
    parameter int VBUS_W  = 10,
    parameter int STEP    = 5,
    parameter int RATED_V = 385
) (
    input  logic [VBUS_W-1:0] cur,
    output logic [VBUS_W-1:0] nxt
);
    logic [VBUS_W:0] sum;

    always_comb begin
        sum = {1'b0, cur} + (VBUS_W+1)'(STEP);
        if (sum >= (VBUS_W+1)'(RATED_V))
            nxt = VBUS_W'(RATED_V);
        else
            nxt = sum[VBUS_W-1:0];
    end
endmodule

// File: rtl/pfc_start_seq.sv
module pfc_start_seq #(
    parameter int CLK_HZ     = 100_000_000,
    parameter int WAIT_MS    = 100,
    parameter int VBUS_W     = 10,
    parameter int IIN_W      = 9,
    parameter int RELAY_V    = 100,
    parameter int RATED_V    = 385,
    parameter int BURST_LO_V = 375,
    parameter int OC_LIMIT   = 210,
    parameter int RAMP_STEP  = 5,
    parameter int RAMP_TICK  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VBUS_W-1:0] vbus_i,
    input  logic [IIN_W-1:0]  iin_i,
    input  logic              burst_en_i,
    output logic              relay_on_o,
    output logic              pwm_en_o,
    output logic [VBUS_W-1:0] vref_o,
    output logic              fault_o
);
    import pfc_seq_pkg::*;

    localparam int WAIT_CYC = CLK_HZ / 1000 * WAIT_MS;
    localparam int TMR_MAX  = (WAIT_CYC > RAMP_TICK) ? WAIT_CYC : RAMP_TICK;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);

    typedef struct packed {
        seq_st_e           st;
        logic              relay;
        logic              pwm;
        logic [VBUS_W-1:0] vref;
        logic [TMR_W-1:0]  tmr;
        logic              fault;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic              above_relay, at_rated, below_lo, over_cur;
    logic [VBUS_W-1:0] ramp_next, load_val;

    pfc_seq_thresh #(
        .VBUS_W(VBUS_W), .IIN_W(IIN_W), .RELAY_V(RELAY_V),
        .RATED_V(RATED_V), .BURST_LO_V(BURST_LO_V), .OC_LIMIT(OC_LIMIT)
    ) thresh_i (
        .vbus(vbus_i), .iin(iin_i), .above_relay(above_relay),
        .at_rated(at_rated), .below_lo(below_lo), .over_cur(over_cur)
    );

    // Stepping adder for the ramp
    pfc_seq_ramp_step #(.VBUS_W(VBUS_W), .STEP(RAMP_STEP), .RATED_V(RATED_V)) step_i (
        .cur(seq_q.vref), .nxt(ramp_next)
    );

    // Same saturating unit with zero step clamps the initial load
    pfc_seq_ramp_step #(.VBUS_W(VBUS_W), .STEP(0), .RATED_V(RATED_V)) clamp_i (
        .cur(vbus_i), .nxt(load_val)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_PRECH: begin
                if (above_relay) begin
                    seq_d.st    = ST_WAIT;
                    seq_d.relay = 1'b1;
                    seq_d.tmr   = '0;
                end
            end
            ST_WAIT: begin
                if (seq_q.tmr == TMR_W'(WAIT_CYC - 1)) begin
                    seq_d.st   = ST_RAMP;
                    seq_d.pwm  = 1'b1;
                    seq_d.vref = load_val;
                    seq_d.tmr  = '0;
                end else begin
                    seq_d.tmr = seq_q.tmr + 1'b1;
                end
            end
            ST_RAMP: begin
                if (seq_q.vref == VBUS_W'(RATED_V)) begin
                    seq_d.st  = ST_RUN;
                    seq_d.tmr = '0;
                end else if (seq_q.tmr == TMR_W'(RAMP_TICK - 1)) begin
                    seq_d.vref = ramp_next;
                    seq_d.tmr  = '0;
                end else begin
                    seq_d.tmr = seq_q.tmr + 1'b1;
                end
            end
            ST_RUN: begin
                if (!burst_en_i)
                    seq_d.pwm = 1'b1;
                else if (at_rated)
                    seq_d.pwm = 1'b0;
                else if (below_lo)
                    seq_d.pwm = 1'b1;
            end
            default: begin
                seq_d.pwm = 1'b0;
            end
        endcase

        if (over_cur) begin
            seq_d.st    = ST_TRIP;
            seq_d.pwm   = 1'b0;
            seq_d.fault = 1'b1;
            seq_d.relay = seq_q.relay;
            seq_d.vref  = seq_q.vref;
            seq_d.tmr   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st    <= ST_PRECH;
            seq_q.relay <= 1'b0;
            seq_q.pwm   <= 1'b0;
            seq_q.vref  <= '0;
            seq_q.tmr   <= '0;
            seq_q.fault <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign relay_on_o = seq_q.relay;
    assign pwm_en_o   = seq_q.pwm;
    assign vref_o     = seq_q.vref;
    assign fault_o    = seq_q.fault;
endmodule

// File: rtl/pfc_start_seq_chk.sv
module pfc_start_seq_chk #(
    parameter int VBUS_W   = 10,
    parameter int IIN_W    = 9,
    parameter int RELAY_V  = 100,
    parameter int RATED_V  = 385,
    parameter int OC_LIMIT = 210
) (
    input logic              clk,
    input logic              rst_n,
    input logic [VBUS_W-1:0] vbus_i,
    input logic [IIN_W-1:0]  iin_i,
    input logic              relay_on_o,
    input logic              pwm_en_o,
    input logic [VBUS_W-1:0] vref_o,
    input logic              fault_o
);
    assert_pwm_needs_relay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en_o |-> relay_on_o);

    assert_relay_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        relay_on_o |=> relay_on_o);

    assert_relay_needs_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relay_on_o) |-> ($past(vbus_i) > VBUS_W'(RELAY_V)));

    assert_trip_on_oc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iin_i > IIN_W'(OC_LIMIT)) |=> (fault_o && !pwm_en_o));

    assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> (fault_o && !pwm_en_o));

    assert_ref_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vref_o <= VBUS_W'(RATED_V));

    assert_ref_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vref_o) != '0) |-> (vref_o >= $past(vref_o)));
endmodule

bind pfc_start_seq pfc_start_seq_chk #(
    .VBUS_W(VBUS_W), .IIN_W(IIN_W), .RELAY_V(RELAY_V),
    .RATED_V(RATED_V), .OC_LIMIT(OC_LIMIT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .vbus_i(vbus_i), .iin_i(iin_i),
    .relay_on_o(relay_on_o), .pwm_en_o(pwm_en_o), .vref_o(vref_o), .fault_o(fault_o)
);

// File: tb/pfc_start_seq_tb_top.sv
module pfc_start_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 20000;
    localparam int WAIT_MS    = 100;
    localparam int WAIT_CYC   = CLK_HZ / 1000 * WAIT_MS;
    localparam int VBUS_W     = 10;
    localparam int IIN_W      = 9;
    localparam int N_VEC      = 10;
    localparam int WDOG_CYC   = 50000;

    // Burst-gate vectors in the running state: burst request, bus sample, expected enable
    localparam int VEC_BURST[N_VEC] = '{1, 1, 1, 1, 1, 1, 1, 0, 1, 1};
    localparam int VEC_VBUS[N_VEC]  = '{380, 385, 380, 376, 375, 384, 390, 390, 390, 370};
    localparam int VEC_PWM[N_VEC]   = '{1, 0, 0, 0, 1, 1, 0, 1, 0, 1};

    logic              clk = 1'b0;
    logic              rst_n;
    logic [VBUS_W-1:0] vbus_i;
    logic [IIN_W-1:0]  iin_i;
    logic              burst_en_i;
    logic              relay_on_o, pwm_en_o, fault_o;
    logic [VBUS_W-1:0] vref_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfc_start_seq #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS), .VBUS_W(VBUS_W), .IIN_W(IIN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .vbus_i(vbus_i), .iin_i(iin_i), .burst_en_i(burst_en_i),
        .relay_on_o(relay_on_o), .pwm_en_o(pwm_en_o), .vref_o(vref_o), .fault_o(fault_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; vbus_i = '0; iin_i = '0; burst_en_i = 1'b0;
        step(3);
        check("R1", "relay in reset", int'(relay_on_o), 0);
        check("R1", "pwm in reset", int'(pwm_en_o), 0);
        check("R1", "vref in reset", int'(vref_o), 0);
        check("R1", "fault in reset", int'(fault_o), 0);
        rst_n = 1'b1;

        // R2: boundary at exactly 100 keeps relay open
        vbus_i = 10'd100;
        step(5);
        check("R2", "relay at 100 V", int'(relay_on_o), 0);
        check("R9", "pwm with relay open", int'(pwm_en_o), 0);
        vbus_i = 10'd101;
        step(1);
        check("R2", "relay at 101 V", int'(relay_on_o), 1);

        // R3: enable exactly WAIT_CYC edges after the relay edge
        vbus_i = 10'd300;
        step(WAIT_CYC - 1);
        check("R3", "pwm one cycle early", int'(pwm_en_o), 0);
        step(1);
        check("R3", "pwm at wait end", int'(pwm_en_o), 1);
        check("R4", "vref loaded from bus", int'(vref_o), 300);

        // R8: high bus during ramp does not stop switching
        vbus_i = 10'd400;
        burst_en_i = 1'b1;
        step(RAMP_TICK_TB - 1);
        check("R5", "vref before first tick", int'(vref_o), 300);
        step(1);
        check("R5", "vref after first tick", int'(vref_o), 305);
        check("R8", "pwm during ramp with high bus", int'(pwm_en_o), 1);
        step(16 * RAMP_TICK_TB);
        check("R5", "vref reaches rated", int'(vref_o), 385);
        burst_en_i = 1'b0;
        step(RAMP_TICK_TB + 2);
        check("R5", "vref saturates", int'(vref_o), 385);
        check("R8", "pwm in run, burst off, high bus", int'(pwm_en_o), 1);

        // R7/R8: burst vector walk
        for (int i = 0; i < N_VEC; i++) begin
            burst_en_i = VEC_BURST[i][0];
            vbus_i     = VBUS_W'(VEC_VBUS[i]);
            step(1);
            check(VEC_BURST[i] != 0 ? "R7" : "R8", $sformatf("burst vector %0d", i),
                  int'(pwm_en_o), VEC_PWM[i]);
        end

        // R6: boundary at 210 does not trip
        iin_i = 9'd210;
        step(2);
        check("R6", "no trip at 21.0 A", int'(fault_o), 0);
        iin_i = 9'd211;
        step(1);
        check("R6", "trip at 21.1 A", int'(fault_o), 1);
        check("R6", "pwm off on trip", int'(pwm_en_o), 0);
        iin_i = '0; vbus_i = 10'd360; burst_en_i = 1'b1;
        step(5);
        check("R6", "fault latched", int'(fault_o), 1);
        check("R6", "pwm held off", int'(pwm_en_o), 0);
        check("R6", "relay held", int'(relay_on_o), 1);
        check("R6", "vref held", int'(vref_o), 385);

        // R1: reset clears the trip
        rst_n = 1'b0; burst_en_i = 1'b0;
        step(1);
        check("R1", "fault cleared by reset", int'(fault_o), 0);
        check("R1", "relay cleared by reset", int'(relay_on_o), 0);
        check("R1", "vref cleared by reset", int'(vref_o), 0);

        // R6: trip during precharge keeps relay open
        vbus_i = 10'd50; iin_i = 9'd300;
        rst_n = 1'b1;
        step(1);
        check("R6", "trip in precharge", int'(fault_o), 1);
        iin_i = '0; vbus_i = 10'd200;
        step(3);
        check("R6", "relay stays open after trip", int'(relay_on_o), 0);
        check("R6", "pwm stays off after trip", int'(pwm_en_o), 0);

        // R4: load clamps to rated level
        rst_n = 1'b0;
        step(1);
        vbus_i = 10'd420;
        rst_n = 1'b1;
        step(1);
        check("R2", "relay closes at 420 V", int'(relay_on_o), 1);
        step(WAIT_CYC);
        check("R4", "vref clamped", int'(vref_o), 385);
        step(1);
        burst_en_i = 1'b1;
        step(1);
        check("R7", "burst stops above rated", int'(pwm_en_o), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    localparam int RAMP_TICK_TB = 4;

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule